// File: doc/BRIEF.md
# Dual-Clock Parallel-Load Shift Register

This block is a parallel-in, serial-out shift register with a default width of eight stages. A word on the parallel inputs is captured whenever the active-low load input is held low. The captured word then leaves one bit at a time on a true output and an inverted output, highest-order bit first, while a serial input fills the register from the low end.

Two external clock inputs decide when a shift happens. They are OR-ed together, and a shift is issued on a rising transition of the result. Either input can therefore serve as the shift clock, and either can serve as an active-low enable for the other: holding one input high hides every edge on the other.

All logic runs on a free-running system clock. The two clock inputs, the load input, the serial input and the parallel word pass through the same synchronizer, so they stay aligned with one another. Load is level-driven. It is applied on every cycle in which the synchronized load is low, and it takes priority over a shift edge seen in the same cycle.

Top module: `psr_top`

## Requirements
- R1: While the synchronized load input is low, every stage takes the matching parallel input bit on each system clock cycle, and `q_out` shows `par_in[WIDTH-1]`.
- R2: A combined-clock rising edge that arrives while load is low causes no shift; the parallel word is held instead.
- R3: After a load, successive shifts present the loaded bits on `q_out` in order from `par_in[WIDTH-1]` down to `par_in[0]`.
- R4: On each shift, stage 0 takes `ser_in` and every other stage takes the value of the stage below it, so serial bits reach `q_out` WIDTH shifts after they enter.
- R5: `q_out_n` is always the inverse of `q_out`.
- R6: A shift occurs when `clk_a | clk_b` changes from 0 to 1, whether the edge comes from `clk_a` alone, `clk_b` alone, or both rising together.
- R7: While one clock input is held high, transitions on the other clock input cause no shift.
- R8: If an input acting as an enable goes from low to high while the other clock input is low, the OR rises and exactly one extra shift occurs.
- R9: With load high and no rising edge of the combined clock (steady high, steady low, or falling), the stages hold their contents.
- R10: Synchronous active-high `rst` clears all stages, so `q_out` is 0 and `q_out_n` is 1. Leaving reset with a clock input already high causes no shift.
- R11: A change on the inputs takes effect on the outputs at the third rising edge of `clk` after it is sampled: two synchronizer stages, then the register update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_a | input | 1 | First external shift clock / enable |
| clk_b | input | 1 | Second external shift clock / enable |
| load_n | input | 1 | Active-low level-sensitive parallel load |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | WIDTH | Parallel load word; bit WIDTH-1 leaves first |
| q_out | output | 1 | True value of the last stage |
| q_out_n | output | 1 | Inverted value of the last stage |

## Verification
The assertions assume that the external inputs change slowly compared with the system clock. Each level must last longer than the synchronizer depth, so the two clock inputs, the serial bit and the parallel word cross into the system clock domain together. They also assume that the serial and parallel data are stable when a combined-clock edge arrives. The stimulus keeps to this by holding every input pattern for at least six system clock cycles. It changes data only in the same step as a clock edge, never between the halves of a synchronizer. Both the directed cases and the random ones change the two clock inputs only at step boundaries.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2
  } act_e;

  // OR of the two external clocks after synchronization
  function automatic logic merge_clocks(input logic a, input logic b);
    return a | b;
  endfunction

  // low-to-high change between two successive samples
  function automatic logic rose(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // load dominates; otherwise an edge shifts; otherwise hold
  function automatic act_e pick_action(input logic load_n_v, input logic edge_v);
    if (!load_n_v)   return ACT_LOAD;
    else if (edge_v) return ACT_SHIFT;
    else             return ACT_HOLD;
  endfunction

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int          W     = 12,
  parameter int          DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RST_VAL;
        else     pipe[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RST_VAL;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[DEPTH-1];

endmodule

// File: rtl/psr_edge.sv
module psr_edge (
  input  logic clk,
  input  logic rst,
  input  logic clk_a_s,
  input  logic clk_b_s,
  output logic comb_now,
  output logic comb_prev
);
  import psr_pkg::*;

  assign comb_now = merge_clocks(clk_a_s, clk_b_s);

  // reset to 1 so that leaving reset never looks like a rising edge
  always_ff @(posedge clk) begin
    if (rst) comb_prev <= 1'b1;
    else     comb_prev <= comb_now;
  end

endmodule

// File: rtl/psr_stages.sv
module psr_stages #(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  psr_pkg::act_e     act,
  input  logic              ser,
  input  logic [WIDTH-1:0]  par,
  output logic [WIDTH-1:0]  stages
);
  import psr_pkg::*;

  function automatic logic [WIDTH-1:0] shift_in(input logic [WIDTH-1:0] v,
                                                input logic bit_in);
    return {v[WIDTH-2:0], bit_in};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      stages <= '0;
    end else begin
      case (act)
        ACT_LOAD:  stages <= par;
        ACT_SHIFT: stages <= shift_in(stages, ser);
        default:   stages <= stages;
      endcase
    end
  end

endmodule

// File: rtl/psr_top.sv
module psr_top #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_out,
  output logic             q_out_n
);
  import psr_pkg::*;

  localparam int BUS_W = WIDTH + 4;
  // clock bits and load reset high, data low
  localparam logic [BUS_W-1:0] BUS_RST = {3'b111, 1'b0, {WIDTH{1'b0}}};

  logic [BUS_W-1:0] bus_raw;
  logic [BUS_W-1:0] bus_s;
  logic             clk_a_s;
  logic             clk_b_s;
  logic             load_n_s;
  logic             ser_s;
  logic [WIDTH-1:0] par_s;

  logic             comb_now;
  logic             comb_prev;
  logic             edge_raw;
  act_e             act;
  logic             load_ev;
  logic             shift_ev;
  logic [WIDTH-1:0] stages;

  assign bus_raw = {clk_a, clk_b, load_n, ser_in, par_in};

  psr_sync #(
    .W      (BUS_W),
    .DEPTH  (SYNC_STAGES),
    .RST_VAL(BUS_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (bus_raw),
    .q  (bus_s)
  );

  assign clk_a_s  = bus_s[BUS_W-1];
  assign clk_b_s  = bus_s[BUS_W-2];
  assign load_n_s = bus_s[BUS_W-3];
  assign ser_s    = bus_s[BUS_W-4];
  assign par_s    = bus_s[WIDTH-1:0];

  psr_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .clk_a_s  (clk_a_s),
    .clk_b_s  (clk_b_s),
    .comb_now (comb_now),
    .comb_prev(comb_prev)
  );

  assign edge_raw = rose(comb_now, comb_prev);
  assign act      = pick_action(load_n_s, edge_raw);
  assign load_ev  = (act == ACT_LOAD);
  assign shift_ev = (act == ACT_SHIFT);

  psr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk   (clk),
    .rst   (rst),
    .act   (act),
    .ser   (ser_s),
    .par   (par_s),
    .stages(stages)
  );

  assign q_out   = stages[WIDTH-1];
  assign q_out_n = ~stages[WIDTH-1];

endmodule

// File: rtl/psr_chk.sv
module psr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load_ev,
  input logic             shift_ev,
  input logic             edge_raw,
  input logic             comb_now,
  input logic             comb_prev,
  input logic             ser_s,
  input logic [WIDTH-1:0] par_s,
  input logic [WIDTH-1:0] stages
);

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> (stages == $past(par_s)));                                  // R1

  AST_LOAD_BEATS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (load_ev && edge_raw) |=> (stages == $past(par_s)));                    // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    shift_ev |=> (stages == {$past(stages[WIDTH-2:0]), $past(ser_s)}));     // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!load_ev && !shift_ev) |=> $stable(stages));                           // R9

  AST_HIGH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (comb_now && comb_prev) |-> !shift_ev);                                 // R7

  AST_EDGE_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    (comb_now && !comb_prev && !load_ev) |-> shift_ev);                     // R6

endmodule

bind psr_top psr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_ev  (load_ev),
  .shift_ev (shift_ev),
  .edge_raw (edge_raw),
  .comb_now (comb_now),
  .comb_prev(comb_prev),
  .ser_s    (ser_s),
  .par_s    (par_s),
  .stages   (stages)
);

// File: tb/psr_top_test.sv
module psr_top_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clk_a = 1'b1;
  logic         clk_b = 1'b0;
  logic         load_n = 1'b1;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         q_out;
  logic         q_out_n;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model = '0;
  logic         prev_or = 1'b1;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  psr_top #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .clk_a(clk_a), .clk_b(clk_b), .load_n(load_n),
    .ser_in(ser_in), .par_in(par_in), .q_out(q_out), .q_out_n(q_out_n)
  );

  // reference: load wins, rising OR shifts from the bottom, else hold
  function automatic logic [W-1:0] ref_next(input logic [W-1:0] cur,
      input logic ld_n, input logic edge_up, input logic s, input logic [W-1:0] p);
    if (!ld_n)        return p;
    else if (edge_up) return {cur[W-2:0], s};
    else              return cur;
  endfunction

  task automatic check(input string tag, input logic act_q, input logic act_qn);
    checks++;
    if (act_q !== model[W-1] || act_qn !== ~model[W-1]) begin
      fails++;
      $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b", tag, act_q, act_qn,
               model[W-1], ~model[W-1]);
    end
  endtask

  // drive one pattern, check at the third edge (R11), then settle
  task automatic step(input string tag, input logic a, input logic b,
                      input logic ld_n, input logic s, input logic [W-1:0] p);
    logic now_or;
    @(negedge clk);
    clk_a = a; clk_b = b; load_n = ld_n; ser_in = s; par_in = p;
    now_or = a | b;
    model = ref_next(model, ld_n, now_or & ~prev_or, s, p);
    prev_or = now_or;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tag, q_out, q_out_n);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R10: reset with clk_a already high
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 in reset", q_out, q_out_n);
    rst = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R10 no shift on release", q_out, q_out_n);
    step("R9 clock falls, hold", 1'b0, 1'b0, 1'b1, 1'b1, '0);

    // R1 load, then R3 shift out MSB first with each clock alone
    step("R1 load", 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    step("R1 release no shift", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    step("R6 clk_a alone R3", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    step("R9 fall hold", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    step("R6 clk_b alone R3", 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    step("R9 fall hold", 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    step("R6 both rise R3", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);

    // R7 clk_b high blocks clk_a
    step("R7 a falls", 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    step("R7 a rises blocked", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    step("R7 a falls", 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    // R8 proper disable: clk_b falls while clk_a high, then clk_a rises? keep legal
    step("R8 b low", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    step("R8 badly timed enable", 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    step("R8 a high", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    step("R8 b low under a", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    step("R8 legal disable", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    step("R8 a low", 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    step("R8 b low", 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);

    // R2 load with concurrent edge
    step("R2 load beats edge", 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C);
    step("R2 fall under load", 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C);
    step("R2 release", 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);

    // R4 serial pattern walks through all stages
    for (int i = 0; i < 2 * W; i++) begin
      step("R4 shift", 1'b1, 1'b0, 1'b1, i[1] ^ i[0], 8'h00);
      step("R4 fall", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    end

    // random mix, R5 on every step
    for (int i = 0; i < 200; i++) begin
      logic ra, rb, rl, rs;
      logic [W-1:0] rp;
      ra = 1'($urandom());
      rb = 1'($urandom());
      rl = ($urandom() % 8) != 0;
      rs = 1'($urandom());
      rp = W'($urandom());
      step("R5 R6 random", ra, rb, rl, rs, rp);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule